// File: doc/BRIEF.md
# Multiplexed Flash Asynchronous Access Sequencer

This block turns single internal read and write requests into the strobe timing of an external NOR-type flash used in asynchronous mode. A requester presents an address, a 32-bit write word with byte enables, and a direction. It holds `req_valid` high until the block answers with a one-cycle `req_ready` pulse. For reads, the returned half-word is on `rsp_rdata` in that same cycle. On the flash side the block drives an address bus, a data bus split into output, output enable and input, and three active-low strobes: address-valid, output-enable and write-enable. All three strobes idle high.

The sequencer runs at twice the strobe rate, so one flash controller cycle equals two `clk` cycles. This lets the write data and address stay driven for half a controller cycle after write-enable rises. When `cfg_mux` is set, the address is also placed on the data bus while address-valid is low. After a read in this mode, the data bus stays reserved for a programmable number of output-enable latency cycles. Address-valid latency and output-enable latency are static configuration inputs. The address-valid latency is supplied minus one.

Top module: `mflash_async_seq`

## Requirements
- R1: While `rst` is high, `fl_avd_n`, `fl_oe_n` and `fl_we_n` are 1, and `fl_dq_oe` and `req_ready` are 0.
- R2: A request is accepted at a clock edge in which the block is idle, `req_valid` is 1 and the post-read reservation has expired. In the cycle after acceptance, `fl_avd_n` goes low. It stays low for exactly 2*(`cfg_avl_m1`+1) cycles, with `fl_addr` equal to `req_addr` throughout.
- R3: While `fl_avd_n` is low, `fl_dq_oe` equals `cfg_mux`. When `cfg_mux` is 1, `fl_dq_o` carries `fl_addr[15:0]`.
- R4: In a write, `fl_we_n` is low for exactly 2 cycles, starting in the cycle right after the address phase. During those cycles `fl_dq_oe` is 1 and `fl_addr` holds the address.
- R5: After `fl_we_n` rises in a write, address and write data stay driven for 1 more cycle. In the next cycle `fl_dq_oe` is 0 and `req_ready` is 1 for that single cycle.
- R6: In a read, 2 cycles with all strobes high and `fl_dq_oe` 0 follow the address phase. `fl_oe_n` is then low for exactly 2 cycles.
- R7: A read returns in `rsp_rdata` the value `fl_dq_i` had at the last clock edge of the `fl_oe_n` low window. `req_ready` is 1 in the cycle in which `fl_oe_n` returns high.
- R8: A write whose `req_be` is neither 4'b0011 nor 4'b1100 is dropped. The strobes stay high and `fl_dq_oe` stays 0, and `req_ready` pulses in the cycle after acceptance.
- R9: For a write with `req_be` 4'b0011, the flash receives `req_wdata[15:0]`. With 4'b1100, it receives `req_wdata[31:16]`.
- R10: After a read completes with `cfg_mux` = 1, exactly 1+2*`cfg_oel` idle cycles separate the `req_ready` cycle from the next address phase, given a pending request. After a write, a dropped write, or any access with `cfg_mux` = 0, the gap is 1 cycle.
- R11: At most one of the three strobes is low in any cycle, and `fl_dq_oe` is never 1 while `fl_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, twice the flash strobe rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mux | input | 1 | 1: address also driven on the data bus |
| cfg_avl_m1 | input | AVL_W (3) | Address-valid length in controller cycles, minus one |
| cfg_oel | input | OEL_W (3) | Post-read data-bus reservation in controller cycles |
| req_valid | input | 1 | Request pending, held until `req_ready` |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | AW (24) | Half-word flash address |
| req_be | input | 4 | Byte enables of the 32-bit word |
| req_wdata | input | 32 | Write word; lane chosen by `req_be` |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read half-word, valid with `req_ready` |
| fl_addr | output | AW (24) | Flash address bus |
| fl_dq_o | output | 16 | Data bus output value |
| fl_dq_oe | output | 1 | Data bus output enable |
| fl_dq_i | input | 16 | Data bus input value |
| fl_avd_n | output | 1 | Address-valid strobe, active low |
| fl_oe_n | output | 1 | Output-enable strobe, active low |
| fl_we_n | output | 1 | Write-enable strobe, active low |

## Verification
The address phase starts one cycle after the accepting edge and lasts 2*(`cfg_avl_m1`+1) cycles. Write-enable then follows at once for 2 cycles, followed by 1 hold cycle and the ready cycle. A read instead passes 2 turnaround cycles and 2 output-enable cycles, and its data and ready appear in the cycle after the capturing edge. The bench turns each request into a queue of per-cycle expected pin values that starts with the idle cycles owed to the previous access, including 1+2*`cfg_oel` after a multiplexed read. It pops one entry at every clock, a quarter period after the rising edge, so each result is compared in the exact cycle it is due.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam int HW_W = 16;        // flash data bus width
    localparam int WORD_W = 2 * HW_W; // request word width
    localparam int BE_W = WORD_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WEN,
        ST_WHOLD,
        ST_TURN,
        ST_RDOE,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic            wr;
        logic [HW_W-1:0] data;
    } lane_req_t;

    // A write is carried out only for an aligned half-word
    function automatic logic is_halfword(input logic [BE_W-1:0] be);
        return (be == 4'b0011) || (be == 4'b1100);
    endfunction

    function automatic logic [HW_W-1:0] pick_lane(input logic [BE_W-1:0] be,
                                                  input logic [WORD_W-1:0] wd);
        return be[2] ? wd[WORD_W-1:HW_W] : wd[HW_W-1:0];
    endfunction

endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
    import fseq_pkg::*;
#(
    parameter int AVL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AVL_W-1:0] cfg_avl_m1,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [BE_W-1:0]  req_be,
    input  logic             gap_clear,
    output seq_state_t       state,
    output logic             accept,
    output logic             capture
);
    localparam int CNT_W = AVL_W + 1;

    logic [CNT_W-1:0] cnt;
    logic             wr_q;

    assign accept  = (state == ST_IDLE) && req_valid && gap_clear;
    assign capture = (state == ST_RDOE) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            wr_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    wr_q <= req_write;
                    if (req_write && !is_halfword(req_be)) begin
                        state <= ST_DONE;
                    end else begin
                        state <= ST_ADDR;
                        cnt   <= {cfg_avl_m1, 1'b1};
                    end
                end
                ST_ADDR: if (cnt == '0) begin
                    state <= wr_q ? ST_WEN : ST_TURN;
                    cnt   <= CNT_W'(1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                ST_WEN: if (cnt == '0) state <= ST_WHOLD;
                        else cnt <= cnt - 1'b1;
                ST_WHOLD: state <= ST_DONE;
                ST_TURN: if (cnt == '0) begin
                    state <= ST_RDOE;
                    cnt   <= CNT_W'(1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                ST_RDOE: if (cnt == '0) state <= ST_DONE;
                         else cnt <= cnt - 1'b1;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Dropped writes must never enter the address phase (R8)
    assert_drop_skips_bus_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && req_write && !is_halfword(req_be)) |=> (state == ST_DONE));

endmodule

// File: rtl/fseq_gap.sv
module fseq_gap #(
    parameter int OEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [OEL_W-1:0] cfg_oel,
    input  logic             in_idle,
    output logic             clear
);
    localparam int GAP_W = OEL_W + 1;

    logic [GAP_W-1:0] left;

    assign clear = (left == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (load) begin
            left <= {cfg_oel, 1'b0};
        end else if (in_idle && !clear) begin
            left <= left - 1'b1;
        end
    end

    // The reservation only ever counts down between loads (R10)
    assert_gap_monotonic_R10: assert property (@(posedge clk) disable iff (rst)
        (!load && !$past(load) && !$past(rst)) |-> (left <= $past(left)));

endmodule

// File: rtl/fseq_pins.sv
module fseq_pins
    import fseq_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_t        state,
    input  logic              accept,
    input  logic              capture,
    input  logic              cfg_mux,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_write,
    input  logic [BE_W-1:0]   req_be,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [HW_W-1:0]   fl_dq_i,
    output logic [AW-1:0]     fl_addr,
    output logic [HW_W-1:0]   fl_dq_o,
    output logic              fl_dq_oe,
    output logic              fl_avd_n,
    output logic              fl_oe_n,
    output logic              fl_we_n,
    output logic              ready,
    output logic [HW_W-1:0]   rdata
);
    logic [AW-1:0] addr_q;
    lane_req_t     lane_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            lane_q <= '0;
            rdata  <= '0;
        end else begin
            if (accept) begin
                addr_q      <= req_addr;
                lane_q.wr   <= req_write;
                lane_q.data <= pick_lane(req_be, req_wdata);
            end
            if (capture) rdata <= fl_dq_i;
        end
    end

    always_comb begin
        fl_addr  = addr_q;
        fl_avd_n = 1'b1;
        fl_oe_n  = 1'b1;
        fl_we_n  = 1'b1;
        fl_dq_oe = 1'b0;
        fl_dq_o  = '0;
        ready    = 1'b0;
        case (state)
            ST_ADDR: begin
                fl_avd_n = 1'b0;
                fl_dq_oe = cfg_mux;
                fl_dq_o  = cfg_mux ? addr_q[HW_W-1:0] : '0;
            end
            ST_WEN: begin
                fl_we_n  = 1'b0;
                fl_dq_oe = 1'b1;
                fl_dq_o  = lane_q.data;
            end
            ST_WHOLD: begin
                fl_dq_oe = 1'b1;
                fl_dq_o  = lane_q.data;
            end
            ST_RDOE: fl_oe_n = 1'b0;
            ST_DONE: ready = 1'b1;
            default: ;
        endcase
    end

    // Write data never appears on the bus during a read access (R6)
    assert_read_no_drive_R6: assert property (@(posedge clk) disable iff (rst)
        (!lane_q.wr && state != ST_ADDR) |-> !fl_dq_oe);

endmodule

// File: rtl/mflash_async_seq.sv
module mflash_async_seq
    import fseq_pkg::*;
#(
    parameter int AW    = 24,
    parameter int AVL_W = 3,
    parameter int OEL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_mux,
    input  logic [AVL_W-1:0]  cfg_avl_m1,
    input  logic [OEL_W-1:0]  cfg_oel,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [HW_W-1:0]   rsp_rdata,
    output logic [AW-1:0]     fl_addr,
    output logic [HW_W-1:0]   fl_dq_o,
    output logic              fl_dq_oe,
    input  logic [HW_W-1:0]   fl_dq_i,
    output logic              fl_avd_n,
    output logic              fl_oe_n,
    output logic              fl_we_n
);
    seq_state_t state;
    logic       accept;
    logic       capture;
    logic       gap_clear;

    fseq_ctrl #(.AVL_W(AVL_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cfg_avl_m1 (cfg_avl_m1),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_be     (req_be),
        .gap_clear  (gap_clear),
        .state      (state),
        .accept     (accept),
        .capture    (capture)
    );

    fseq_gap #(.OEL_W(OEL_W)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .load    (capture && cfg_mux),
        .cfg_oel (cfg_oel),
        .in_idle (state == ST_IDLE),
        .clear   (gap_clear)
    );

    fseq_pins #(.AW(AW)) u_pins (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .accept    (accept),
        .capture   (capture),
        .cfg_mux   (cfg_mux),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .fl_dq_i   (fl_dq_i),
        .fl_addr   (fl_addr),
        .fl_dq_o   (fl_dq_o),
        .fl_dq_oe  (fl_dq_oe),
        .fl_avd_n  (fl_avd_n),
        .fl_oe_n   (fl_oe_n),
        .fl_we_n   (fl_we_n),
        .ready     (req_ready),
        .rdata     (rsp_rdata)
    );

    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        $countones({~fl_avd_n, ~fl_oe_n, ~fl_we_n}) <= 1);

    assert_no_contention_R11: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> !fl_dq_oe);

    assert_mux_address_R3: assert property (@(posedge clk) disable iff (rst)
        (!fl_avd_n && cfg_mux) |-> (fl_dq_oe && fl_dq_o == fl_addr[HW_W-1:0]));

    assert_we_after_addr_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(fl_we_n) |-> $past(!fl_avd_n));

    assert_oe_turnaround_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(fl_oe_n) |-> ($past(fl_avd_n) && $past(fl_avd_n, 2)));

    assert_ready_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);

    assert_release_on_ready_R5: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!fl_dq_oe && fl_we_n && fl_oe_n && fl_avd_n));

    assert_read_capture_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_oe_n) |-> (req_ready && rsp_rdata == $past(fl_dq_i)));

    assert_gap_before_addr_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(fl_avd_n) |-> $past(gap_clear));

endmodule

// File: tb/mflash_async_seq_tb.sv
module mflash_async_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_mux;
    logic [2:0]  cfg_avl_m1;
    logic [2:0]  cfg_oel;
    logic        req_valid;
    logic        req_write;
    logic [AW-1:0] req_addr;
    logic [3:0]  req_be;
    logic [31:0] req_wdata;
    logic        req_ready;
    logic [15:0] rsp_rdata;
    logic [AW-1:0] fl_addr;
    logic [15:0] fl_dq_o;
    logic        fl_dq_oe;
    logic [15:0] fl_dq_i;
    logic        fl_avd_n, fl_oe_n, fl_we_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mflash_async_seq u_dut (
        .clk(clk), .rst(rst), .cfg_mux(cfg_mux), .cfg_avl_m1(cfg_avl_m1),
        .cfg_oel(cfg_oel), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata), .fl_addr(fl_addr),
        .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i),
        .fl_avd_n(fl_avd_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    typedef struct {
        logic        avd_n, oe_n, we_n, dq_oe, ready;
        bit          chk_addr, chk_dq, chk_rd;
        logic [AW-1:0] addr;
        logic [15:0] dq, rd;
        int          rq;   // requirement number the cycle belongs to
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   blocked = 0;   // idle cycles still owed before the next address phase

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic cmp(int rq, string what, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h at %0t", rq, what, got, exp, $time);
        end
    endtask

    function automatic exp_t idle_rec(int rq);
        exp_t e;
        e.avd_n = 1; e.oe_n = 1; e.we_n = 1; e.dq_oe = 0; e.ready = 0;
        e.chk_addr = 0; e.chk_dq = 0; e.chk_rd = 0;
        e.addr = '0; e.dq = '0; e.rd = '0; e.rq = rq;
        return e;
    endfunction

    // One clock: sample a quarter period after the rising edge, compare to the model
    task automatic step();
        exp_t e;
        @(posedge clk);
        #(CLK_PERIOD / 4);
        e = (q.size() > 0) ? q.pop_front() : idle_rec(1);
        cmp(e.rq, "avd_n", 32'(fl_avd_n), 32'(e.avd_n));
        cmp(e.rq, "oe_n", 32'(fl_oe_n), 32'(e.oe_n));
        cmp(e.rq, "we_n", 32'(fl_we_n), 32'(e.we_n));
        cmp(e.rq, "dq_oe", 32'(fl_dq_oe), 32'(e.dq_oe));
        cmp(e.rq, "ready", 32'(req_ready), 32'(e.ready));
        if (e.chk_addr) cmp(e.rq, "addr", 32'(fl_addr), 32'(e.addr));
        if (e.chk_dq) cmp(e.rq, "dq_o", 32'(fl_dq_o), 32'(e.dq));
        if (e.chk_rd) cmp(e.rq, "rdata", 32'(rsp_rdata), 32'(e.rd));
        // R11: single strobe and no drive while the flash drives
        cmp(11, "strobes low", 32'($countones({~fl_avd_n, ~fl_oe_n, ~fl_we_n}) <= 1), 32'd1);
        cmp(11, "contention", 32'(!fl_oe_n && fl_dq_oe), 32'd0);
        if (e.ready) req_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
        blocked = (blocked > n) ? blocked - n : 0;
    endtask

    task automatic issue(bit wr, logic [AW-1:0] a, logic [3:0] be,
                         logic [31:0] wd, logic [15:0] fd);
        exp_t e;
        int   n_addr = 2 * (int'(cfg_avl_m1) + 1);
        logic [15:0] lane = (be == 4'b1100) ? wd[31:16] : wd[15:0];
        req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
        fl_dq_i = fd; req_valid = 1'b1;
        // R10: idle cycles owed to the previous access
        for (int i = 0; i < blocked; i++) q.push_back(idle_rec(10));
        if (wr && !(be == 4'b0011 || be == 4'b1100)) begin
            // R8: dropped write, only a ready pulse
            e = idle_rec(8); e.ready = 1; q.push_back(e);
        end else begin
            for (int i = 0; i < n_addr; i++) begin
                e = idle_rec(cfg_mux ? 3 : 2);   // R2 / R3 address phase
                e.avd_n = 0; e.dq_oe = cfg_mux; e.chk_addr = 1; e.addr = a;
                e.chk_dq = cfg_mux; e.dq = a[15:0];
                q.push_back(e);
            end
            if (wr) begin
                for (int i = 0; i < 2; i++) begin
                    e = idle_rec((be == 4'b1100) ? 9 : 4);   // R4 / R9
                    e.we_n = 0; e.dq_oe = 1; e.chk_addr = 1; e.addr = a;
                    e.chk_dq = 1; e.dq = lane;
                    q.push_back(e);
                end
                e = idle_rec(5);   // R5 half-cycle hold
                e.dq_oe = 1; e.chk_addr = 1; e.addr = a; e.chk_dq = 1; e.dq = lane;
                q.push_back(e);
                e = idle_rec(5); e.ready = 1; q.push_back(e);
            end else begin
                for (int i = 0; i < 2; i++) begin
                    e = idle_rec(6); e.chk_addr = 1; e.addr = a; q.push_back(e);
                end
                for (int i = 0; i < 2; i++) begin
                    e = idle_rec(6); e.oe_n = 0; e.chk_addr = 1; e.addr = a; q.push_back(e);
                end
                e = idle_rec(7); e.ready = 1; e.chk_rd = 1; e.rd = fd; q.push_back(e);
            end
        end
        while (q.size() > 0) step();
        blocked = 1 + ((!wr && cfg_mux) ? 2 * int'(cfg_oel) : 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        rst = 1; cfg_mux = 0; cfg_avl_m1 = 0; cfg_oel = 2;
        req_valid = 0; req_write = 0; req_addr = '0; req_be = '0;
        req_wdata = '0; fl_dq_i = '0;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD / 4);
        // R1: reset state
        cmp(1, "reset avd_n", 32'(fl_avd_n), 32'd1);
        cmp(1, "reset oe_n", 32'(fl_oe_n), 32'd1);
        cmp(1, "reset we_n", 32'(fl_we_n), 32'd1);
        cmp(1, "reset dq_oe", 32'(fl_dq_oe), 32'd0);
        cmp(1, "reset ready", 32'(req_ready), 32'd0);
        rst = 0;
        idle(2);

        // Non-multiplexed: latency has no effect after reads
        issue(1, 24'h012345, 4'b0011, 32'hBEEF_1234, 16'h0);
        issue(0, 24'h000100, 4'b1111, 32'h0, 16'hA5C3);
        issue(0, 24'h000102, 4'b0000, 32'h0, 16'h5A3C);
        issue(1, 24'hABCDEF, 4'b1100, 32'hCAFE_0001, 16'h0);

        // Multiplexed, longer address phase, reservation after reads
        idle(3);
        cfg_mux = 1; cfg_avl_m1 = 2; cfg_oel = 2;
        idle(1);
        issue(0, 24'h00F00D, 4'b1111, 32'h0, 16'h1357);
        issue(0, 24'h00F00E, 4'b1111, 32'h0, 16'h2468);
        issue(1, 24'h777777, 4'b1100, 32'h9ABC_DEF0, 16'h0);
        issue(0, 24'h000042, 4'b1111, 32'h0, 16'hFFFF);
        issue(1, 24'h111111, 4'b1111, 32'h1111_1111, 16'h0);
        issue(1, 24'h222222, 4'b0001, 32'h2222_2222, 16'h0);
        issue(0, 24'h333333, 4'b1111, 32'h0, 16'h0F0F);

        // Reservation partly consumed by waiting before the next request
        idle(2);
        issue(0, 24'h444444, 4'b1111, 32'h0, 16'h8001);

        // Multiplexed with zero latency
        cfg_oel = 0; cfg_avl_m1 = 0;
        issue(0, 24'h000010, 4'b1111, 32'h0, 16'h4242);
        issue(1, 24'h000012, 4'b0011, 32'h0000_7E7E, 16'h0);
        idle(4);

        summary();
        $finish;
    end

endmodule